// File: doc/BRIEF.md
# Key-Protected System Configuration Register File

This block is a small register file inside a system controller. Two of its registers carry settings that must not change by accident: a device-configuration word that steers shared pins between peripherals, and an audio clock-divider word. Software reaches them only through a one-shot unlock. It writes the key value 0xAA to the lock register, which arms the unlock. The next write to either protected register is then accepted, and that write uses the unlock up.

The block also holds a read-only system-information word that carries a chip-revision field. It decodes the device-configuration word into pin-routing select outputs for the keypad controller, the second PWM output and the I2S signals. It presents the stored divider on a port for the clock logic that follows. The bus is a single-cycle write strobe with a combinational read path. All addresses are word indices.

Top module: `syscfg_lockregs`

## Requirements
- R1: After reset the unlock is disarmed, the device-configuration word (address 1) reads 0x3, and the divider word (address 2) reads 0.
- R2: A write of exactly 0xAA to the lock register (address 0) arms the unlock. Reading address 0 returns 1 while the unlock is armed and 0 otherwise.
- R3: A write of any other value to the lock register disarms the unlock.
- R4: A write to address 1 or address 2 while the unlock is armed is stored, and it disarms the unlock.
- R5: A write to address 1 or address 2 while the unlock is disarmed leaves both registers unchanged.
- R6: A write to address 3 or to an unmapped address (4 and above) leaves the armed state unchanged.
- R7: An armed write to address 1 with both bit 3 and bit 4 set is rejected. The register keeps its value and the unlock is still used up.
- R8: `keypad_owns_ports` is 1 exactly when device-configuration bits 0 and 1 are both 0.
- R9: `pwm2_on_pin` follows device-configuration bit 2, `i2s_on_ssp` follows bit 3 and `i2s_on_ac97` follows bit 4. Bits above 4 read 0.
- R10: Address 3 reads the revision parameter in bits 7:4 and 0 in all other bits. Writes to address 3 have no effect.
- R11: Unmapped addresses read 0.
- R12: The divider register stores the low 16 bits of the written data, drives them on `aud_clk_div`, and reads 0 in the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| keypad_owns_ports | output | 1 | Two GPIO ports are routed to the keypad controller |
| pwm2_on_pin | output | 1 | Second PWM output is routed to its shared GPIO pin |
| i2s_on_ssp | output | 1 | I2S is routed onto the synchronous serial port pins |
| i2s_on_ac97 | output | 1 | I2S is routed onto the AC97 pins |
| aud_clk_div | output | 16 | Stored audio clock-divider value |

## Verification
A wrong armed state shows in the lock readback on the very next read. It also shows one cycle after the following protected write, when a select output or `aud_clk_div` either changes when it should hold or holds when it should change. A corrupted device-configuration word reaches the routing selects in the cycle after the write, so comparing the outputs on every clock against a behavioural model catches it within one cycle. The bench drives sequences in which arming is followed by cancelling, by non-protected writes and by rejected writes, so that an unlock that is used up or kept wrongly leaks into a later write.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;
  localparam int A_LOCK    = 0;
  localparam int A_DEVCFG  = 1;
  localparam int A_CLKDIV  = 2;
  localparam int A_SYSINFO = 3;

  localparam int CFG_W       = 5;
  localparam int B_KPD_A     = 0;
  localparam int B_KPD_B     = 1;
  localparam int B_PWM2      = 2;
  localparam int B_I2S_SSP   = 3;
  localparam int B_I2S_AC97  = 4;

  localparam logic [CFG_W-1:0] CFG_RESET = 5'b00011;

  typedef struct packed {
    logic keypad_owns_ports;
    logic pwm2_on_pin;
    logic i2s_on_ssp;
    logic i2s_on_ac97;
  } route_t;
endpackage

// File: rtl/syscfg_unlock.sv
module syscfg_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_wr,
  input  logic key_ok,
  input  logic prot_wr,
  output logic armed
);
  logic armed_q, armed_d, armed_en;

  always_comb begin
    armed_en = lock_wr | prot_wr;
    armed_d  = armed_q;
    if (lock_wr)      armed_d = key_ok;
    else if (prot_wr) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed = armed_q;
endmodule

// File: rtl/syscfg_prot_reg.sv
module syscfg_prot_reg #(
  parameter int          W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_wr,
  input  logic         armed,
  input  logic         data_ok,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;
  logic         q_en;

  always_comb begin
    q_en = sel_wr & armed & data_ok;
    q_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= RST;
    else if (q_en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/syscfg_route_decode.sv
module syscfg_route_decode
  import syscfg_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output route_t           route
);
  always_comb begin
    route.keypad_owns_ports = ~(cfg[B_KPD_A] | cfg[B_KPD_B]);
    route.pwm2_on_pin       = cfg[B_PWM2];
    route.i2s_on_ssp        = cfg[B_I2S_SSP];
    route.i2s_on_ac97       = cfg[B_I2S_AC97];
  end
endmodule

// File: rtl/syscfg_lockregs.sv
module syscfg_lockregs
  import syscfg_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 4,
  parameter int          DIV_W   = 16,
  parameter int          REV_W   = 4,
  parameter int          REV_LSB = 4,
  parameter logic [REV_W-1:0] REVISION = 4'h2,
  parameter logic [DATA_W-1:0] LOCK_KEY = 32'h0000_00AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              keypad_owns_ports,
  output logic              pwm2_on_pin,
  output logic              i2s_on_ssp,
  output logic              i2s_on_ac97,
  output logic [DIV_W-1:0]  aud_clk_div
);
  localparam int PAD_CFG = DATA_W - CFG_W;
  localparam int PAD_DIV = DATA_W - DIV_W;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic wr_lock, wr_cfg, wr_div, prot_wr, key_ok, cfg_ok, armed;
  logic [CFG_W-1:0] devcfg_q;
  logic [DIV_W-1:0] clkdiv_q;
  route_t           route;

  always_comb begin
    wr_lock = bus_wr & (bus_addr == ADDR_W'(A_LOCK));
    wr_cfg  = bus_wr & (bus_addr == ADDR_W'(A_DEVCFG));
    wr_div  = bus_wr & (bus_addr == ADDR_W'(A_CLKDIV));
    prot_wr = wr_cfg | wr_div;
    key_ok  = (bus_wdata == LOCK_KEY);
    cfg_ok  = ~(bus_wdata[B_I2S_SSP] & bus_wdata[B_I2S_AC97]);
  end

  syscfg_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lock_wr (wr_lock),
    .key_ok  (key_ok),
    .prot_wr (prot_wr),
    .armed   (armed)
  );

  syscfg_prot_reg #(.W(CFG_W), .RST(CFG_RESET)) u_devcfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel_wr  (wr_cfg),
    .armed   (armed),
    .data_ok (cfg_ok),
    .wdata   (bus_wdata[CFG_W-1:0]),
    .q       (devcfg_q)
  );

  syscfg_prot_reg #(.W(DIV_W), .RST('0)) u_clkdiv (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel_wr  (wr_div),
    .armed   (armed),
    .data_ok (1'b1),
    .wdata   (bus_wdata[DIV_W-1:0]),
    .q       (clkdiv_q)
  );

  syscfg_route_decode u_route (
    .cfg   (devcfg_q),
    .route (route)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_LOCK):    bus_rdata = {{(DATA_W-1){1'b0}}, armed};
      ADDR_W'(A_DEVCFG):  bus_rdata = {{PAD_CFG{1'b0}}, devcfg_q};
      ADDR_W'(A_CLKDIV):  bus_rdata = {{PAD_DIV{1'b0}}, clkdiv_q};
      ADDR_W'(A_SYSINFO): bus_rdata[REV_LSB +: REV_W] = REVISION;
      default:            bus_rdata = '0;
    endcase
  end

  assign keypad_owns_ports = route.keypad_owns_ports;
  assign pwm2_on_pin       = route.pwm2_on_pin;
  assign i2s_on_ssp        = route.i2s_on_ssp;
  assign i2s_on_ac97       = route.i2s_on_ac97;
  assign aud_clk_div       = clkdiv_q;
endmodule

// File: rtl/syscfg_lockregs_chk.sv
module syscfg_lockregs_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 16,
  parameter int CFG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              armed,
  input logic [CFG_W-1:0]  devcfg_q,
  input logic [DIV_W-1:0]  clkdiv_q,
  input logic              i2s_on_ssp,
  input logic              i2s_on_ac97
);
  logic prot_w;
  assign prot_w = bus_wr && (bus_addr == ADDR_W'(1) || bus_addr == ADDR_W'(2));

  AST_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata == DATA_W'(32'hAA)) |=> armed); // R2

  AST_BAD_KEY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata != DATA_W'(32'hAA)) |=> !armed); // R3

  AST_UNLOCK_USED_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_w && armed) |=> !armed); // R4

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_w && !armed) |=> ($stable(devcfg_q) && $stable(clkdiv_q))); // R5

  AST_OTHER_WRITE_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr >= ADDR_W'(3)) |=> (armed == $past(armed))); // R6

  AST_DUAL_I2S_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[3] && bus_wdata[4]) |=> $stable(devcfg_q)); // R7

  AST_I2S_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(i2s_on_ssp && i2s_on_ac97)); // R7
endmodule

bind syscfg_lockregs syscfg_lockregs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CFG_W(syscfg_pkg::CFG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .armed       (armed),
  .devcfg_q    (devcfg_q),
  .clkdiv_q    (clkdiv_q),
  .i2s_on_ssp  (i2s_on_ssp),
  .i2s_on_ac97 (i2s_on_ac97)
);

// File: tb/tb_syscfg_lockregs.sv
module tb_syscfg_lockregs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        keypad_owns_ports, pwm2_on_pin, i2s_on_ssp, i2s_on_ac97;
  logic [15:0] aud_clk_div;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;

  // behavioural reference state
  bit       m_armed;
  int       m_cfg;
  int       m_div;

  always #(CLK_PERIOD/2) clk = ~clk;

  syscfg_lockregs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .keypad_owns_ports(keypad_owns_ports), .pwm2_on_pin(pwm2_on_pin),
    .i2s_on_ssp(i2s_on_ssp), .i2s_on_ac97(i2s_on_ac97), .aud_clk_div(aud_clk_div)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of the routing outputs against the model (R8, R9, R12)
  always @(negedge clk) begin
    if (model_on) begin
      check("R8", "keypad_owns_ports", keypad_owns_ports, ((m_cfg & 3) == 0) ? 1 : 0);
      check("R9", "pwm2_on_pin", pwm2_on_pin, (m_cfg >> 2) & 1);
      check("R9", "i2s_on_ssp", i2s_on_ssp, (m_cfg >> 3) & 1);
      check("R9", "i2s_on_ac97", i2s_on_ac97, (m_cfg >> 4) & 1);
      check("R12", "aud_clk_div", aud_clk_div, m_div);
    end
  end

  task automatic model_write(input int a, input longint d);
    if (a == 0) m_armed = (d == 64'hAA);
    else if (a == 1 || a == 2) begin
      if (m_armed) begin
        if (a == 2) m_div = int'(d & 64'hFFFF);
        else if (!(((d >> 3) & 1) == 1 && ((d >> 4) & 1) == 1)) m_cfg = int'(d & 64'h1F);
      end
      m_armed = 1'b0;
    end
  endtask

  task automatic wr(input int a, input longint d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 32'(d);
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input longint exp, input string req);
    bus_addr = 4'(a);
    #1;
    check(req, $sformatf("read addr %0d", a), bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_armed = 1'b0; m_cfg = 3; m_div = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_on = 1'b1;

    // R1 reset state
    rd(0, 0, "R1"); rd(1, 3, "R1"); rd(2, 0, "R1");

    // R5 locked writes ignored
    wr(1, 0); rd(1, 3, "R5");
    wr(2, 16'h55); rd(2, 0, "R5");

    // R2 arm and read back
    wr(0, 32'hAA); rd(0, 1, "R2");

    // R6 and R10: non-protected writes keep arm, sysinfo is read-only
    wr(3, 32'hFFFF_FFFF); rd(0, 1, "R6"); rd(3, 32'h0000_0020, "R10");
    wr(9, 32'h1234); rd(0, 1, "R6"); rd(9, 0, "R11"); rd(15, 0, "R11");

    // R4 armed write accepted and used up; R8/R9 via per-clock compare
    wr(1, 32'hFFFF_FFE4); rd(1, 4, "R4"); rd(0, 0, "R4");
    wr(1, 3); rd(1, 4, "R5");

    // R3 wrong key cancels
    wr(0, 32'hAA); wr(0, 32'h55); rd(0, 0, "R3");
    wr(1, 8); rd(1, 4, "R3");
    wr(0, 32'h1AA); rd(0, 0, "R3");

    // R7 both I2S bits rejected, unlock still used up
    wr(0, 32'hAA); wr(1, 32'h18); rd(1, 4, "R7"); rd(0, 0, "R7");

    // R9 each I2S routing
    wr(0, 32'hAA); wr(1, 32'h08); rd(1, 8, "R9");
    wr(0, 32'hAA); wr(1, 32'h13); rd(1, 32'h13, "R9");
    wr(0, 32'hAA); wr(1, 32'h01); rd(1, 1, "R8");

    // R12 divider width
    wr(0, 32'hAA); wr(2, 32'hABCD_1234); rd(2, 32'h1234, "R12"); rd(0, 0, "R12");

    // R4 one unlock serves one write only
    wr(0, 32'hAA); wr(0, 32'hAA); wr(2, 32'h0777); wr(2, 32'h0999);
    rd(2, 32'h0777, "R4");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule